// File: doc/BRIEF.md
# Latching Pulse-Loss Fault Monitor

This block watches a periodic pulse stream, such as a fan tachometer or a heartbeat toggled by a processor. Once started, it expects a rising edge at least every `MAX_GAP` clock cycles. When the gap between edges grows longer than that, the block reports a fault on an active-low output, `fault_n`. After a long arming delay has passed since power-up, that fault latches. It then holds until a power-on reset or a debounced press of a clear button, which makes it a persistent fault indication rather than a one-off reset pulse.

Power-up runs through three delays measured from the release of `por_n`:

- A reset hold of `RST_CYC` cycles, during which `fault_n` is driven low.
- A startup blanking interval of `BLANK_CYC` cycles, during which a missing pulse is not treated as a fault, so the monitored device can spin up.
- A latch-arm delay of `ARM_CYC` cycles. Before it runs out, a timeout only produces one reset-length low pulse.

These delays must satisfy RST_CYC < BLANK_CYC < ARM_CYC. A parameter set that breaks this order stops elaboration with an error.

The controller has five named states:

| State | Output | Exit |
|---|---|---|
| ST_PWRUP | output held low | to ST_BLANK after `RST_CYC` cycles |
| ST_BLANK | output high, gaps ignored | to ST_WATCH once the blanking time is reached |
| ST_WATCH | output high, gap timer running | a rising pulse edge restarts the timer; a full gap goes to ST_PULSE when unarmed, or to ST_LATCH when armed |
| ST_PULSE | output low | back to ST_WATCH after `RST_CYC` cycles |
| ST_LATCH | output low, indicator on | to ST_WATCH on a debounced clear press |

Top module: `pulse_loss_monitor`

## Requirements
- R1: After `por_n` is released, `fault_n` stays low for `RST_CYC` cycles and then goes high.
- R2: While `por_n` is low, `fault_n` and `fault_led` are both low, whatever state the block was in before.
- R3: No fault is declared during the first `BLANK_CYC` cycles after `por_n` is released, even when no pulses arrive.
- R4: While rising edges of `pulse_in` arrive at most `MAX_GAP` cycles apart, `fault_n` stays high.
- R5: A gap longer than `MAX_GAP` cycles that ends before `ARM_CYC` cycles after reset gives one low pulse of `RST_CYC` cycles on `fault_n`. `fault_led` stays low, and `fault_n` then returns high.
- R6: A gap longer than `MAX_GAP` cycles after arming latches the fault: `fault_n` low and `fault_led` high. The fault holds even if pulses resume.
- R7: A latched fault is released only by `por_n` or by `clr_btn` (active high) held steady for 16 consecutive synchronized samples. Bounces shorter than that have no effect.
- R8: A clear press while no fault is latched has no effect on `fault_n` or `fault_led`.
- R9: Only rising edges of `pulse_in` count. An input held high is a missing pulse stream and leads to a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pulse_in | input | 1 | Monitored pulse stream, asynchronous |
| clr_btn | input | 1 | Clear pushbutton, active high, asynchronous and bouncy |
| fault_n | output | 1 | Active-low fault and reset output |
| fault_led | output | 1 | High while a fault is latched |

## Verification
The embedded assertions check on every cycle that:
- a latch holds until a clear event;
- no latch forms before arming;
- the output never leaves the blanking states while blanking runs;
- the gap timer and the pulse timer stay inside their windows;
- the arm flag never drops;
- the debounced level only changes after a full stable count.

Only the bench scenarios can show the externally timed behaviour:
- the length of the power-up hold;
- that an unarmed timeout gives a single low pulse and does not latch;
- that resumed pulses do not release a latch;
- that bounce shorter than 16 samples leaves the latch in place;
- that a clear press in normal running is ignored;
- that a high-held input counts as pulse loss.

// File: rtl/plm_pkg.sv
package plm_pkg;
    typedef enum logic [2:0] {
        ST_PWRUP = 3'd0,
        ST_BLANK = 3'd1,
        ST_WATCH = 3'd2,
        ST_PULSE = 3'd3,
        ST_LATCH = 3'd4
    } plm_state_t;
endpackage

// File: rtl/plm_sync.sv
module plm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/plm_debounce.sv
module plm_debounce #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level,
    output logic press
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            level <= 1'b0;
            press <= 1'b0;
        end else begin
            press <= 1'b0;
            if (raw == level) begin
                cnt <= '0;
            end else if (cnt == CNT_LAST) begin
                cnt   <= '0;
                level <= raw;
                press <= raw;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R7
    deb_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != CNT_LAST) |=> $stable(level));
endmodule

// File: rtl/plm_age.sv
module plm_age #(
    parameter int BLANK_CYC = 200,
    parameter int ARM_CYC   = 600
) (
    input  logic clk,
    input  logic rst_n,
    output logic blank_done,
    output logic armed
);
    localparam int AW = $clog2(ARM_CYC + 1);
    localparam logic [AW-1:0] AGE_TOP   = AW'(ARM_CYC);
    localparam logic [AW-1:0] AGE_BLANK = AW'(BLANK_CYC);

    logic [AW-1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age <= '0;
        else if (age != AGE_TOP) age <= age + 1'b1;
    end

    assign blank_done = (age >= AGE_BLANK);
    assign armed      = (age == AGE_TOP);

    // R6
    arm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
endmodule

// File: rtl/pulse_loss_monitor.sv
module pulse_loss_monitor
    import plm_pkg::*;
#(
    parameter int RST_CYC     = 20,
    parameter int BLANK_CYC   = 200,
    parameter int ARM_CYC     = 600,
    parameter int MAX_GAP     = 50,
    parameter int DEB_LEN     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic pulse_in,
    input  logic clr_btn,
    output logic fault_n,
    output logic fault_led
);
    localparam int TOPV = (MAX_GAP > ARM_CYC) ? MAX_GAP : ARM_CYC;
    localparam int TW   = $clog2(TOPV + 1);
    localparam logic [TW-1:0] RST_LAST = TW'(RST_CYC - 1);
    localparam logic [TW-1:0] GAP_LAST = TW'(MAX_GAP - 1);

    generate
        if (!((RST_CYC < BLANK_CYC) && (BLANK_CYC < ARM_CYC))) begin : g_order_bad
            $error("pulse_loss_monitor: delays must satisfy RST_CYC < BLANK_CYC < ARM_CYC");
        end
    endgenerate

    logic pulse_s, pulse_d, pulse_rise;
    logic clr_s, clr_level, clr_press;
    logic blank_done, armed;

    plm_sync #(.STAGES(SYNC_STAGES)) u_pulse_sync (
        .clk(clk), .rst_n(por_n), .d(pulse_in), .q(pulse_s));

    plm_sync #(.STAGES(SYNC_STAGES)) u_clr_sync (
        .clk(clk), .rst_n(por_n), .d(clr_btn), .q(clr_s));

    plm_debounce #(.LEN(DEB_LEN)) u_clr_deb (
        .clk(clk), .rst_n(por_n), .raw(clr_s), .level(clr_level), .press(clr_press));

    plm_age #(.BLANK_CYC(BLANK_CYC), .ARM_CYC(ARM_CYC)) u_age (
        .clk(clk), .rst_n(por_n), .blank_done(blank_done), .armed(armed));

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) pulse_d <= 1'b0;
        else        pulse_d <= pulse_s;
    end
    assign pulse_rise = pulse_s & ~pulse_d;

    plm_state_t    state, nxt;
    logic [TW-1:0] tmr, tmr_nxt;

    always_comb begin
        nxt     = state;
        tmr_nxt = tmr;
        unique case (state)
            ST_PWRUP: begin
                if (tmr == RST_LAST) begin
                    nxt     = ST_BLANK;
                    tmr_nxt = '0;
                end else begin
                    tmr_nxt = tmr + 1'b1;
                end
            end
            ST_BLANK: begin
                if (blank_done) begin
                    nxt     = ST_WATCH;
                    tmr_nxt = '0;
                end
            end
            ST_WATCH: begin
                if (pulse_rise) begin
                    tmr_nxt = '0;
                end else if (tmr == GAP_LAST) begin
                    nxt     = armed ? ST_LATCH : ST_PULSE;
                    tmr_nxt = '0;
                end else begin
                    tmr_nxt = tmr + 1'b1;
                end
            end
            ST_PULSE: begin
                if (tmr == RST_LAST) begin
                    nxt     = ST_WATCH;
                    tmr_nxt = '0;
                end else begin
                    tmr_nxt = tmr + 1'b1;
                end
            end
            ST_LATCH: begin
                if (clr_press) begin
                    nxt     = ST_WATCH;
                    tmr_nxt = '0;
                end
            end
            default: begin
                nxt     = ST_PWRUP;
                tmr_nxt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= ST_PWRUP;
            tmr   <= '0;
        end else begin
            state <= nxt;
            tmr   <= tmr_nxt;
        end
    end

    always_comb begin
        fault_n   = 1'b1;
        fault_led = 1'b0;
        unique case (state)
            ST_PWRUP, ST_PULSE: fault_n = 1'b0;
            ST_LATCH: begin
                fault_n   = 1'b0;
                fault_led = 1'b1;
            end
            default: fault_n = 1'b1;
        endcase
    end

    // R6
    latch_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_LATCH && !clr_press) |=> (state == ST_LATCH));

    // R5
    no_early_latch_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state != ST_LATCH && !armed) |=> (state != ST_LATCH));

    // R3
    blank_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        !blank_done |-> (state == ST_PWRUP || state == ST_BLANK));

    // R4
    gap_window_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_WATCH) |-> (tmr <= GAP_LAST));

    // R5
    pulse_window_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_PULSE) |-> (tmr <= RST_LAST));

    // R8
    clr_idle_chk: assert property (@(posedge clk) disable iff (!por_n)
        (state == ST_WATCH && clr_press && !pulse_rise && tmr != GAP_LAST) |=> (state == ST_WATCH));
endmodule

// File: tb/sim_pulse_loss_monitor.sv
module sim_pulse_loss_monitor;
    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic pulse_in = 1'b0;
    logic clr_btn = 1'b0;
    logic fault_n, fault_led;

    logic pulse_on = 1'b0;
    logic hold_high = 1'b0;
    int   pcnt = 0;
    int   cyc = 0;
    int   checks = 0;
    int   failures = 0;
    bit   done = 1'b0;

    always #10 clk = ~clk;

    pulse_loss_monitor u0 (
        .clk(clk), .por_n(por_n), .pulse_in(pulse_in), .clr_btn(clr_btn),
        .fault_n(fault_n), .fault_led(fault_led));

    always @(posedge clk) begin
        if (!por_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    always @(negedge clk) begin
        pcnt <= (pcnt == 19) ? 0 : pcnt + 1;
        if (hold_high) pulse_in <= 1'b1;
        else           pulse_in <= pulse_on && (pcnt < 3);
    end

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s at cyc %0d: actual=%b expected=%b", req, cyc, act, exp);
        end
    endtask

    task automatic wait_cyc(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        check("R2 fault_n in reset", fault_n, 1'b0);
        check("R2 fault_led in reset", fault_led, 1'b0);
        por_n = 1'b1;
    endtask

    task automatic t_powerup;
        wait_cyc(10);
        check("R1 held low after release", fault_n, 1'b0);
        wait_cyc(25);
        check("R1 high after hold", fault_n, 1'b1);
    endtask

    task automatic t_blank_and_pulse;
        wait_cyc(190);
        check("R3 no fault while blanking", fault_n, 1'b1);
        wait_cyc(258);
        check("R5 unarmed timeout low", fault_n, 1'b0);
        check("R5 no latch indicator", fault_led, 1'b0);
        wait_cyc(285);
        check("R5 returns high", fault_n, 1'b1);
        pulse_on = 1'b1;
    endtask

    task automatic t_running_and_ignored_clear;
        wait_cyc(400);
        check("R4 steady pulses", fault_n, 1'b1);
        wait_cyc(420);
        clr_btn = 1'b1;
        wait_cyc(460);
        clr_btn = 1'b0;
        wait_cyc(480);
        check("R8 clear ignored fault_n", fault_n, 1'b1);
        check("R8 clear ignored led", fault_led, 1'b0);
        wait_cyc(650);
        check("R4 steady pulses after arm", fault_n, 1'b1);
    endtask

    task automatic t_latch;
        wait_cyc(700);
        pulse_on = 1'b0;
        wait_cyc(770);
        check("R6 latched fault_n", fault_n, 1'b0);
        check("R6 latched led", fault_led, 1'b1);
        wait_cyc(800);
        pulse_on = 1'b1;
        wait_cyc(900);
        check("R6 holds with pulses back", fault_n, 1'b0);
        check("R6 led holds", fault_led, 1'b1);
    endtask

    task automatic t_clear;
        wait_cyc(910);
        for (int i = 0; i < 4; i++) begin
            clr_btn = 1'b1;
            repeat (5) @(negedge clk);
            clr_btn = 1'b0;
            repeat (5) @(negedge clk);
        end
        wait_cyc(970);
        check("R7 bounce keeps latch", fault_led, 1'b1);
        wait_cyc(980);
        clr_btn = 1'b1;
        wait_cyc(1020);
        clr_btn = 1'b0;
        wait_cyc(1030);
        check("R7 clear releases fault_n", fault_n, 1'b1);
        check("R7 clear releases led", fault_led, 1'b0);
    endtask

    task automatic t_held_high;
        wait_cyc(1100);
        hold_high = 1'b1;
        wait_cyc(1170);
        check("R9 held-high input latches", fault_n, 1'b0);
        check("R9 held-high led", fault_led, 1'b1);
    endtask

    task automatic t_por_release;
        wait_cyc(1200);
        por_n = 1'b0;
        hold_high = 1'b0;
        pulse_on = 1'b0;
        repeat (3) @(negedge clk);
        check("R2 por clears fault_n", fault_n, 1'b0);
        check("R2 por clears led", fault_led, 1'b0);
        por_n = 1'b1;
        wait_cyc(10);
        check("R1 second power-up low", fault_n, 1'b0);
        check("R7 por released latch led", fault_led, 1'b0);
        wait_cyc(25);
        check("R1 second power-up high", fault_n, 1'b1);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        t_reset;
        t_powerup;
        t_blank_and_pulse;
        t_running_and_ignored_clear;
        t_latch;
        t_clear;
        t_held_high;
        t_por_release;
        finish_run;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired at cyc %0d: actual=timeout expected=finish", cyc);
        finish_run;
    end
endmodule